// File: doc/BRIEF.md
# Atomic-Write Interrupt Controller

This block gathers up to fifteen interrupt source lines into one 32-bit control and status word and drives a single interrupt request to a CPU. Each source line that goes high latches a sticky pending flag. Software holds a per-source enable mask and a global enable bit. The request to the CPU is raised when the global enable is on and at least one pending source is also enabled.

Writes act on individual bits, so software never needs a read-modify-write sequence. Bit 31 of each written word does two jobs. It becomes the new global enable. It also chooses whether the ones in the enable field switch those sources on or off. Ones written in the pending field acknowledge those sources. Zeros written in either field leave the matching bits unchanged.

The word can be read at any time. One write strobe and one data bus are assumed to be already decoded for this register.

Top module: `atomic_irq_ctl`

## Requirements
- R1: After a synchronous reset the register reads 0x00000000 and `cpu_irq` is low.
- R2: A source line high at a clock edge sets its pending flag, at bit position equal to the source index in bits 14:0. The flag stays set after the line drops.
- R3: A write clears each pending flag whose bit in 14:0 is 1 and leaves the flags written as 0 unchanged. If the source line is still high in that cycle, the flag reads as set afterwards.
- R4: Every write loads the global enable (bit 31) from bit 31 of the written data, including writes that only acknowledge sources.
- R5: A write with bit 31 high sets each enable in bits 30:16 that is written as 1 and keeps the other enables. A cycle with no write leaves all enables unchanged.
- R6: A write with bit 31 low clears each enable in bits 30:16 that is written as 1, so writing 0x7FFF0000 disables every source.
- R7: Bit 15 reads 1 exactly when some source is both enabled (bits 30:16) and pending (bits 14:0). Writing bit 15 has no effect.
- R8: `cpu_irq` is registered. After each clock edge it equals the value of (bit 31 AND bit 15) that the register held before that edge.
- R9: With fewer than fifteen sources, unused positions read as zero in both the enable field and the pending field, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Write data |
| src_lines | input | NSRC | Interrupt source lines, active high |
| rdata | output | 32 | Current control and status word |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
Directed phases first raise single-cycle pulses on isolated sources, so that sticky latching can be told apart from a plain level follow. Enable writes with bit 31 set and then clear show that the set and clear directions do not leak into untouched positions. Acknowledges are issued both with the source released and with it still high, which separates a true clear from level re-triggering. A long random mix of writes and source activity, with a narrow four-source instance alongside, is compared on every clock against a behavioural model. This exposes wrong global-enable updates, the one-clock lag of the request, and stray bits in unused positions.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int MAX_SRC = 15;

    typedef struct packed {
        logic                glb_en;
        logic [MAX_SRC-1:0]  en;
        logic                any;
        logic [MAX_SRC-1:0]  pend;
    } ctl_word_t;

    function automatic logic [MAX_SRC-1:0] src_mask(input int n);
        logic [MAX_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_SRC; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int                             W    = 15,
    parameter logic [W-1:0]                   MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic         ack_stb,
    input  logic [W-1:0] ack_bits,
    output logic [W-1:0] pend_q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        if (MASK[i]) begin : g_used
            always_ff @(posedge clk) begin
                if (rst)
                    pend_q[i] <= 1'b0;
                else if (src[i])
                    pend_q[i] <= 1'b1;
                else if (ack_stb && ack_bits[i])
                    pend_q[i] <= 1'b0;
            end
        end else begin : g_unused
            assign pend_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int           W    = 15,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic         set_mode,
    input  logic [W-1:0] sel_bits,
    output logic         glb_en_q,
    output logic [W-1:0] en_q
);
    logic [W-1:0] en_next;

    always_comb begin
        en_next = en_q;
        if (wr_stb) begin
            if (set_mode) en_next = en_q | sel_bits;
            else          en_next = en_q & ~sel_bits;
        end
        en_next = en_next & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            glb_en_q <= 1'b0;
        end else begin
            en_q <= en_next;
            if (wr_stb) glb_en_q <= set_mode;
        end
    end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         glb_en,
    input  logic [W-1:0] en,
    input  logic [W-1:0] pend,
    output logic         any,
    output logic         irq_q
);
    assign any = |(en & pend);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= glb_en & any;
    end
endmodule

// File: rtl/atomic_irq_ctl.sv
module atomic_irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int NSRC = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  logic [31:0]     wdata,
    input  logic [NSRC-1:0] src_lines,
    output logic [31:0]     rdata,
    output logic            cpu_irq
);
    localparam logic [MAX_SRC-1:0] SRC_MASK = src_mask(NSRC);

    ctl_word_t          wr_word;
    ctl_word_t          rd_word;
    logic [MAX_SRC-1:0] src_pad;
    logic [MAX_SRC-1:0] pend_q;
    logic [MAX_SRC-1:0] en_q;
    logic               glb_en_q;
    logic               any_w;
    logic               wr_unused_any;

    assign wr_word       = ctl_word_t'(wdata);
    assign wr_unused_any = wr_word.any;

    always_comb begin
        src_pad             = '0;
        src_pad[NSRC-1:0]   = src_lines;
    end

    irq_pend_bank #(.W(MAX_SRC), .MASK(SRC_MASK)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .src      (src_pad),
        .ack_stb  (wr_stb),
        .ack_bits (wr_word.pend),
        .pend_q   (pend_q)
    );

    irq_enable_bank #(.W(MAX_SRC), .MASK(SRC_MASK)) u_en (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .set_mode (wr_word.glb_en),
        .sel_bits (wr_word.en),
        .glb_en_q (glb_en_q),
        .en_q     (en_q)
    );

    irq_summary #(.W(MAX_SRC)) u_sum (
        .clk    (clk),
        .rst    (rst),
        .glb_en (glb_en_q),
        .en     (en_q),
        .pend   (pend_q),
        .any    (any_w),
        .irq_q  (cpu_irq)
    );

    always_comb begin
        rd_word.glb_en = glb_en_q;
        rd_word.en     = en_q;
        rd_word.any    = any_w;
        rd_word.pend   = pend_q;
    end

    assign rdata = rd_word;
endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker #(
    parameter int NSRC = 15
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_stb,
    input logic [31:0]     wdata,
    input logic [NSRC-1:0] src_lines,
    input logic [31:0]     rdata,
    input logic            cpu_irq
);
    localparam logic [14:0] M = irq_ctl_pkg::src_mask(NSRC);

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cpu_irq == ($past(rdata[31]) && $past(rdata[15]))); // R8

    AST_GLB_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_stb) |=> rdata[31] == $past(wdata[31])); // R4

    AST_SRC_LATCH: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rdata[NSRC-1:0] & $past(src_lines)) == $past(src_lines)); // R2

    AST_ANY_SUM: assert property (@(posedge clk) disable iff (rst)
        rdata[15] == |(rdata[30:16] & rdata[14:0])); // R7

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_stb && wdata[31]) |=>
            (rdata[30:16] & $past(wdata[30:16]) & M) == ($past(wdata[30:16]) & M)); // R5

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !wr_stb) |=> $stable(rdata[31:16])); // R5

    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_stb && !wdata[31]) |=> (rdata[30:16] & $past(wdata[30:16])) == 15'h0); // R6

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((rdata[30:16] & ~M) == 15'h0) && ((rdata[14:0] & ~M) == 15'h0)); // R9
endmodule

bind atomic_irq_ctl irq_ctl_checker #(.NSRC(NSRC)) u_irq_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wdata     (wdata),
    .src_lines (src_lines),
    .rdata     (rdata),
    .cpu_irq   (cpu_irq)
);

// File: tb/atomic_irq_ctl_tb.sv
module atomic_irq_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NARROW     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [31:0] wdata = '0;
    logic [14:0] src = '0;
    logic [31:0] rdata_w, rdata_n;
    logic        irq_w, irq_n;

    int    n_checks = 0;
    int    n_errors = 0;
    string req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    atomic_irq_ctl #(.NSRC(15)) dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wdata(wdata),
        .src_lines(src), .rdata(rdata_w), .cpu_irq(irq_w)
    );

    atomic_irq_ctl #(.NSRC(NARROW)) dut_n (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wdata(wdata),
        .src_lines(src[NARROW-1:0]), .rdata(rdata_n), .cpu_irq(irq_n)
    );

    // behavioural reference: index 0 = full instance, 1 = narrow instance
    logic [14:0] m_mask [2];
    logic [14:0] m_en   [2];
    logic [14:0] m_pend [2];
    logic        m_glb  [2];
    logic        m_irq  [2];

    initial begin
        m_mask[0] = 15'h7FFF;
        m_mask[1] = 15'h000F;
    end

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_en[k] = '0; m_pend[k] = '0; m_glb[k] = 1'b0; m_irq[k] = 1'b0;
            end else begin
                m_irq[k] = m_glb[k] && ((m_en[k] & m_pend[k]) != 0);
                if (wr_stb) m_pend[k] = m_pend[k] & ~wdata[14:0];
                m_pend[k] = (m_pend[k] | src) & m_mask[k];
                if (wr_stb) begin
                    if (wdata[31]) m_en[k] = (m_en[k] | wdata[30:16]) & m_mask[k];
                    else           m_en[k] = m_en[k] & ~wdata[30:16];
                    m_glb[k] = wdata[31];
                end
            end
        end
    end

    function automatic logic [31:0] m_word(int k);
        return {m_glb[k], m_en[k], (m_en[k] & m_pend[k]) != 0, m_pend[k]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check({req, " word"},        rdata_w, m_word(0));
        check({req, " irq"},         {31'd0, irq_w}, {31'd0, m_irq[0]});
        check({req, " narrow word"}, rdata_n, m_word(1));
        check({req, " narrow irq"},  {31'd0, irq_n}, {31'd0, m_irq[1]});
    endtask

    task automatic write(logic [31:0] d);
        wr_stb = 1'b1;
        wdata  = d;
        tick();
        wr_stb = 1'b0;
        wdata  = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        req = "R1";
        check("R1 reset word", rdata_w, 32'h0);
        check("R1 reset irq", {31'd0, irq_w}, 32'h0);

        // R2: single-cycle pulses stick
        req = "R2";
        src = 15'h0001; tick();
        src = 15'h0000; tick();
        src = 15'h4020; tick();
        src = 15'h0000; repeat (2) tick();
        check("R2 sticky flags", {17'd0, rdata_w[14:0]}, 32'h0000_4021);

        // R5: set enables for 0 and 5, then 14 while keeping the others
        req = "R5";
        write(32'h8021_0000);
        write(32'hC000_0000);
        check("R5 enables kept", {17'd0, rdata_w[30:16]}, 32'h0000_4021);

        // R8: request one clock after state
        req = "R8";
        tick();
        check("R8 irq high", {31'd0, irq_w}, 32'h1);

        // R3: acknowledge with source low, then with source held high
        req = "R3";
        write(32'h8000_0001);
        check("R3 ack clears bit0", {31'd0, rdata_w[0]}, 32'h0);
        src = 15'h0020;
        write(32'h8000_0020);
        check("R3 level retrigger", {31'd0, rdata_w[5]}, 32'h1);
        src = 15'h0000;
        write(32'h8000_0020);

        // R4: ack-only write with bit31 low drops global enable
        req = "R4";
        write(32'h0000_4000);
        check("R4 global off", {31'd0, rdata_w[31]}, 32'h0);
        tick();
        check("R4 irq off", {31'd0, irq_w}, 32'h0);

        // R7: bit 15 write ignored
        req = "R7";
        src = 15'h0002; tick(); src = 15'h0;
        write(32'h0000_8000);
        check("R7 any ignores write", {31'd0, rdata_w[15]}, 32'h0);

        // R6: clear one enable, then clear all
        req = "R6";
        write(32'h8002_0000);
        write(32'h0020_0000);
        check("R6 clear one", {17'd0, rdata_w[30:16]}, 32'h0000_4003);
        write(32'h7FFF_0000);
        check("R6 clear all", {17'd0, rdata_w[30:16]}, 32'h0);

        // R9: narrow instance unused positions
        req = "R9";
        src = 15'h7FFF;
        write(32'hFFFF_0000);
        src = 15'h0;
        check("R9 narrow fields", rdata_n, 32'h800F_800F);

        // mixed random traffic, model compared each clock
        req = "R8";
        for (int i = 0; i < 400; i++) begin
            src = 15'($urandom) & 15'($urandom) & 15'($urandom);
            if (($urandom % 3) == 0) begin
                wr_stb = 1'b1;
                wdata  = $urandom;
            end
            tick();
            wr_stb = 1'b0;
            wdata  = '0;
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule